// File: doc/BRIEF.md
# Reconfigurable 2D Window Address Generator

This block drives the read port of an image memory so that a 2D correlation datapath receives its pixels in the order it consumes them. It also supplies the write address for each result pixel the datapath returns. Software or a host FSM sets the fetch style, the image size and the kernel size on the configuration inputs, then pulses `start`. The block captures the configuration on that pulse and walks every output position in raster order.

Two fetch styles share one coordinate walker and one clamp-and-linearise path. The full-window style reads every kernel tap for each output position, row by row within the window. The reuse style reads the first window of an image row column by column. After that it fetches only the single column that enters the window as the output moves one pixel to the right. Any kernel tap that falls outside the image is steered to the nearest edge pixel, so the datapath sees an image padded by border replication.

Read addresses use a valid/ready pair, and the consumer can stall them. Write addresses follow the datapath's result-valid strobe. A one-cycle `done` pulse closes the job.

Top module: `agu_win_gen`

## Requirements
- R1: A `start` pulse while idle captures `cfg_mode`, `cfg_big_kernel`, `cfg_width` and `cfg_height` and begins a job. A `start` pulse or a configuration change during a job has no effect on that job's addresses.
- R2: With `cfg_mode`=0 (full window), each output position (ox,oy), taken in raster order, issues K*K reads. The row offset dy runs from -K/2 to +K/2 as the outer loop and the column offset dx runs over the same range as the inner loop.
- R3: With `cfg_mode`=1 (column reuse), an output position with ox=0 issues K*K reads: dx is the outer loop and dy the inner loop, both from -K/2 to +K/2. Every other position issues K reads at dx=+K/2, with dy rising from -K/2 to +K/2.
- R4: Each tap coordinate is clamped separately before the address is formed: x = min(max(ox+dx,0),W-1) and y = min(max(oy+dy,0),H-1).
- R5: The read address is y*W + x, and it is always below W*H.
- R6: `cfg_big_kernel`=0 selects K=3 and `cfg_big_kernel`=1 selects K=5.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` holds its value, so that no address is lost or skipped.
- R8: `wr_valid` rises in the cycle after `res_valid` is sampled high during a job. The write addresses of a job run 0, 1, ..., W*H-1, one per accepted strobe.
- R9: `done` is high for exactly one cycle, in the cycle after the write address W*H-1. The block is then idle, and neither `res_valid` there nor a strobe beyond W*H results produces a write.
- R10: After reset, `rd_valid`, `wr_valid` and `done` are low.
- R11: Once the last read of a job has been accepted, `rd_valid` stays low until the next job. A full-window job issues W*H*K*K reads and a reuse job issues H*(K*K + (W-1)*K) reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a job when idle |
| cfg_mode | input | 1 | 0 = full-window fetch, 1 = column-reuse fetch |
| cfg_big_kernel | input | 1 | 0 = 3x3 kernel, 1 = 5x5 kernel |
| cfg_width | input | XW (8) | Image width W, 1 or more |
| cfg_height | input | YW (8) | Image height H, 1 or more |
| rd_ready | input | 1 | Consumer accepts the current read address |
| res_valid | input | 1 | Datapath has a result to store |
| rd_addr | output | AW (16) | Read address |
| rd_valid | output | 1 | `rd_addr` is valid |
| wr_addr | output | AW (16) | Write address for a result pixel |
| wr_valid | output | 1 | `wr_addr` is valid |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
A read handshake and a result strobe can fall in the same cycle. The two address streams advance independently, so each must keep its own order when both move at once. The bench provokes this by raising `res_valid` in the same cycle that completes the last read a result needs, while `rd_ready` follows irregular stall patterns. The bench judges every accepted read against a trace computed from the clamp formula. It also checks the cycle in which each write appears and the address it carries. The last write and the `done` pulse are checked the same way, and so is the state of both streams after the job ends.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_REUSE = 1'b1
  } fetch_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  localparam int KSMALL = 3;
  localparam int KLARGE = 5;

endpackage

// File: rtl/agu_walker.sv
// Steps output position and kernel tap in the order the selected fetch style needs.
module agu_walker #(
  parameter int XW  = 8,
  parameter int YW  = 8,
  parameter int KIW = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  step,
  input  agu_pkg::fetch_mode_e  mode,
  input  logic [XW-1:0]         img_w,
  input  logic [YW-1:0]         img_h,
  input  logic [KIW-1:0]        kdim,
  output logic [XW-1:0]         ox,
  output logic [YW-1:0]         oy,
  output logic [KIW-1:0]        kx,
  output logic [KIW-1:0]        ky,
  output logic                  active
);
  import agu_pkg::*;

  logic [KIW-1:0] klast;
  logic           x_end, y_end, kx_end, ky_end, px_adv, act_n;
  logic [XW-1:0]  ox_n;
  logic [YW-1:0]  oy_n;
  logic [KIW-1:0] kx_n, ky_n;

  assign klast  = kdim - 1'b1;
  assign x_end  = (ox == img_w - 1'b1);
  assign y_end  = (oy == img_h - 1'b1);
  assign kx_end = (kx == klast);
  assign ky_end = (ky == klast);

  always_comb begin
    ox_n   = ox;
    oy_n   = oy;
    kx_n   = kx;
    ky_n   = ky;
    act_n  = active;
    px_adv = 1'b0;
    if (mode == MODE_FULL) begin
      // row of taps inner, rows outer
      if (kx_end) begin
        kx_n = '0;
        if (ky_end) begin
          ky_n   = '0;
          px_adv = 1'b1;
        end else begin
          ky_n = ky + 1'b1;
        end
      end else begin
        kx_n = kx + 1'b1;
      end
    end else begin
      // column of taps inner, columns outer
      if (ky_end) begin
        ky_n = '0;
        if (kx_end) px_adv = 1'b1;
        else        kx_n = kx + 1'b1;
      end else begin
        ky_n = ky + 1'b1;
      end
    end
    if (px_adv) begin
      if (x_end) begin
        ox_n = '0;
        kx_n = '0;
        if (y_end) act_n = 1'b0;
        else       oy_n  = oy + 1'b1;
      end else begin
        ox_n = ox + 1'b1;
        // reuse style keeps the window and fetches only the entering column
        kx_n = (mode == MODE_REUSE) ? klast : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ox     <= '0;
      oy     <= '0;
      kx     <= '0;
      ky     <= '0;
      active <= 1'b0;
    end else if (load) begin
      ox     <= '0;
      oy     <= '0;
      kx     <= '0;
      ky     <= '0;
      active <= 1'b1;
    end else if (step && active) begin
      ox     <= ox_n;
      oy     <= oy_n;
      kx     <= kx_n;
      ky     <= ky_n;
      active <= act_n;
    end
  end

endmodule

// File: rtl/agu_clamp_addr.sv
// Applies the tap offset, clamps each axis to the image and forms y*W+x.
module agu_clamp_addr #(
  parameter int XW  = 8,
  parameter int YW  = 8,
  parameter int AW  = 16,
  parameter int KIW = 3
) (
  input  logic [XW-1:0]  ox,
  input  logic [YW-1:0]  oy,
  input  logic [KIW-1:0] kx,
  input  logic [KIW-1:0] ky,
  input  logic [KIW-1:0] krad,
  input  logic [XW-1:0]  img_w,
  input  logic [YW-1:0]  img_h,
  output logic [AW-1:0]  addr
);
  localparam int SX = XW + 2;
  localparam int SY = YW + 2;

  logic signed [SX-1:0] xs;
  logic signed [SY-1:0] ys;
  logic [XW-1:0]        xc;
  logic [YW-1:0]        yc;

  assign xs = $signed({2'b00, ox}) + $signed(SX'(kx)) - $signed(SX'(krad));
  assign ys = $signed({2'b00, oy}) + $signed(SY'(ky)) - $signed(SY'(krad));

  always_comb begin
    if (xs < 0)                          xc = '0;
    else if ($unsigned(xs) >= SX'(img_w)) xc = img_w - 1'b1;
    else                                 xc = xs[XW-1:0];
  end

  always_comb begin
    if (ys < 0)                          yc = '0;
    else if ($unsigned(ys) >= SY'(img_h)) yc = img_h - 1'b1;
    else                                 yc = ys[YW-1:0];
  end

  assign addr = AW'(yc) * AW'(img_w) + AW'(xc);

endmodule

// File: rtl/agu_wr_seq.sv
// Result address counter: one address per accepted result strobe, end-of-job pulse.
module agu_wr_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          en,
  input  logic          res_valid,
  input  logic [AW-1:0] total,
  output logic [AW-1:0] wr_addr,
  output logic          wr_valid,
  output logic          last,
  output logic          done
);
  logic [AW-1:0] cnt;

  assign last = wr_valid && (wr_addr == total - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      wr_addr  <= '0;
      wr_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (clear) begin
        cnt      <= '0;
        wr_valid <= 1'b0;
      end else if (en && res_valid && (cnt < total)) begin
        wr_addr  <= cnt;
        wr_valid <= 1'b1;
        cnt      <= cnt + 1'b1;
      end else begin
        wr_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/agu_win_gen.sv
module agu_win_gen #(
  parameter int XW  = 8,
  parameter int YW  = 8,
  parameter int AW  = 16,
  parameter int KIW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cfg_mode,
  input  logic          cfg_big_kernel,
  input  logic [XW-1:0] cfg_width,
  input  logic [YW-1:0] cfg_height,
  input  logic          rd_ready,
  input  logic          res_valid,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [AW-1:0] wr_addr,
  output logic          wr_valid,
  output logic          done
);
  import agu_pkg::*;

  run_state_e     state;
  fetch_mode_e    mode_q;
  logic           big_q;
  logic [XW-1:0]  w_q;
  logic [YW-1:0]  h_q;
  logic [AW-1:0]  total_q;
  logic [KIW-1:0] kdim, krad;
  logic           start_acc, busy, advance, wr_last;
  logic [XW-1:0]  ox;
  logic [YW-1:0]  oy;
  logic [KIW-1:0] kx, ky;
  logic           walk_active;
  logic [AW-1:0]  addr_c;

  assign busy      = (state == ST_RUN);
  assign start_acc = start && !busy;
  assign kdim      = big_q ? KIW'(KLARGE) : KIW'(KSMALL);
  assign krad      = kdim >> 1;
  assign advance   = !rd_valid || rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= MODE_FULL;
      big_q   <= 1'b0;
      w_q     <= XW'(1);
      h_q     <= YW'(1);
      total_q <= '0;
    end else if (start_acc) begin
      state   <= ST_RUN;
      mode_q  <= fetch_mode_e'(cfg_mode);
      big_q   <= cfg_big_kernel;
      w_q     <= cfg_width;
      h_q     <= cfg_height;
      total_q <= AW'(cfg_width) * AW'(cfg_height);
    end else if (busy && wr_last) begin
      state <= ST_IDLE;
    end
  end

  agu_walker #(.XW(XW), .YW(YW), .KIW(KIW)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .load   (start_acc),
    .step   (advance && busy),
    .mode   (mode_q),
    .img_w  (w_q),
    .img_h  (h_q),
    .kdim   (kdim),
    .ox     (ox),
    .oy     (oy),
    .kx     (kx),
    .ky     (ky),
    .active (walk_active)
  );

  agu_clamp_addr #(.XW(XW), .YW(YW), .AW(AW), .KIW(KIW)) u_addr (
    .ox    (ox),
    .oy    (oy),
    .kx    (kx),
    .ky    (ky),
    .krad  (krad),
    .img_w (w_q),
    .img_h (h_q),
    .addr  (addr_c)
  );

  // registered read port with hold under back-pressure
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
    end else if (start_acc) begin
      rd_valid <= 1'b0;
    end else if (advance) begin
      rd_valid <= walk_active && busy;
      rd_addr  <= addr_c;
    end
  end

  agu_wr_seq #(.AW(AW)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_acc),
    .en        (busy),
    .res_valid (res_valid),
    .total     (total_q),
    .wr_addr   (wr_addr),
    .wr_valid  (wr_valid),
    .last      (wr_last),
    .done      (done)
  );

endmodule

// File: rtl/agu_win_gen_chk.sv
module agu_win_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          res_valid,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          done,
  input logic [AW-1:0] total,
  input logic          busy
);
  logic [AW-1:0] exp_w;

  always_ff @(posedge clk) begin
    if (rst)           exp_w <= '0;
    else if (done)     exp_w <= '0;
    else if (wr_valid) exp_w <= exp_w + 1'b1;
  end

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  p_rd_range_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_addr < total);

  p_wr_cause_r8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(res_valid) && $past(busy));

  p_wr_order_r8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_addr == exp_w);

  p_done_last_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr_valid) && ($past(wr_addr) == total - 1'b1));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind agu_win_gen agu_win_gen_chk #(.AW(AW)) chk (
  .clk       (clk),
  .rst       (rst),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .res_valid (res_valid),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .done      (done),
  .total     (total_q),
  .busy      (busy)
);

// File: tb/agu_win_gen_test.sv
`timescale 1ns/1ps
module agu_win_gen_test;
  localparam int XW = 8, YW = 8, AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          start = 1'b0, mode = 1'b0, big = 1'b0, rd_ready = 1'b0, res_valid = 1'b0;
  logic [XW-1:0] w = 8'd1;
  logic [YW-1:0] h = 8'd1;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          rd_valid, wr_valid, done;

  int checks = 0, failures = 0;
  bit finished = 0;
  int exp_rd [0:4095];
  int need   [0:1023];
  int n_rd, n_px;

  agu_win_gen #(.XW(XW), .YW(YW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(mode), .cfg_big_kernel(big),
    .cfg_width(w), .cfg_height(h), .rd_ready(rd_ready), .res_valid(res_valid),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .wr_addr(wr_addr), .wr_valid(wr_valid),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  // Reference trace from R2, R3, R4, R5, R6
  task automatic build_ref(input bit m, input int ww, input int hh, input int k);
    int r;
    r = k / 2;
    n_rd = 0;
    n_px = 0;
    for (int oy = 0; oy < hh; oy++) begin
      for (int ox = 0; ox < ww; ox++) begin
        if (!m) begin
          for (int dy = -r; dy <= r; dy++)
            for (int dx = -r; dx <= r; dx++) begin
              exp_rd[n_rd] = clampi(oy+dy, hh-1)*ww + clampi(ox+dx, ww-1);
              n_rd++;
            end
        end else if (ox == 0) begin
          for (int dx = -r; dx <= r; dx++)
            for (int dy = -r; dy <= r; dy++) begin
              exp_rd[n_rd] = clampi(oy+dy, hh-1)*ww + clampi(ox+dx, ww-1);
              n_rd++;
            end
        end else begin
          for (int dy = -r; dy <= r; dy++) begin
            exp_rd[n_rd] = clampi(oy+dy, hh-1)*ww + clampi(ox+r, ww-1);
            n_rd++;
          end
        end
        need[n_px] = n_rd;
        n_px++;
      end
    end
  endtask

  task automatic run_job(input bit m, input int ww, input int hh, input bit bk,
                         input int pat, input bit poke);
    int ra, ws, wseen, cyc, rfail;
    bit prev_res, exp_done, got_done, rdy;
    string tag;
    build_ref(m, ww, hh, bk ? 5 : 3);
    tag = m ? "R3 R4 R5 R6" : "R2 R4 R5 R6";
    @(negedge clk);
    mode = m; w = XW'(ww); h = YW'(hh); big = bk; start = 1'b1;
    rd_ready = 1'b0; res_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    ra = 0; ws = 0; wseen = 0; cyc = 0; rfail = 0;
    prev_res = 0; exp_done = 0; got_done = 0;
    while (!got_done && cyc < 20000) begin
      // R8: write appears exactly one cycle after an accepted strobe
      chk(wr_valid == prev_res, "R8", "wr_valid timing", int'(wr_valid), int'(prev_res));
      if (wr_valid) begin
        chk(int'(wr_addr) == wseen, "R8", "wr_addr", int'(wr_addr), wseen);
        wseen++;
      end
      // R9: done only right after the last write
      chk(done == exp_done, "R9", "done timing", int'(done), int'(exp_done));
      if (done) got_done = 1;
      exp_done = wr_valid && (int'(wr_addr) == n_px - 1);
      // R11: no read after the trace is exhausted
      if (ra >= n_rd) chk(!rd_valid, "R11", "rd_valid after last read", int'(rd_valid), 0);
      // drive next cycle
      case (pat)
        0:       rdy = 1'b1;
        1:       rdy = (cyc % 3) != 2;
        default: rdy = ((cyc * 7 + 3) % 5) < 2;
      endcase
      rd_ready = rdy;
      if (rd_valid && rdy && ra < n_rd) begin
        checks++;
        if (int'(rd_addr) != exp_rd[ra]) begin
          failures++;
          if (rfail < 5)
            $display("FAIL %s rd_addr index %0d actual=%0d expected=%0d", tag, ra, rd_addr, exp_rd[ra]);
          rfail++;
        end
        ra++;
      end
      res_valid = (ws < n_px) && (ra >= need[ws]) && (((cyc * 5 + 1) % 4) != 0);
      if (res_valid) ws++;
      prev_res = res_valid;
      // R1: start with a different configuration in mid-job
      if (poke && cyc == 20) begin
        start = 1'b1; mode = ~m; big = ~bk; w = 8'd5; h = 8'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    chk(got_done, "R9", "done seen", int'(got_done), 1);
    chk(ra == n_rd, "R11", "read count", ra, n_rd);
    chk(wseen == n_px, "R8", "write count", wseen, n_px);
    // R9: idle after done ignores strobes; R11: no more reads
    rd_ready = 1'b1;
    res_valid = 1'b1;
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!wr_valid, "R9", "wr_valid in idle", int'(wr_valid), 0);
      chk(!rd_valid, "R11", "rd_valid in idle", int'(rd_valid), 0);
      chk(!done, "R9", "done single cycle", int'(done), 0);
    end
    res_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL R11 watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!rd_valid, "R10", "rd_valid in reset", int'(rd_valid), 0);
    chk(!wr_valid, "R10", "wr_valid in reset", int'(wr_valid), 0);
    chk(!done, "R10", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_valid && !wr_valid && !done, "R10", "outputs after reset", int'(rd_valid | wr_valid | done), 0);

    for (int m = 0; m < 2; m++)
      for (int bk = 0; bk < 2; bk++) begin
        run_job(m[0], 8, 4, bk[0], (m + bk) % 3, 1'b0);
        run_job(m[0], 10, 5, bk[0], (m + bk + 1) % 3, 1'b0);
      end
    // R1: ignored restart during a job
    run_job(1'b1, 8, 4, 1'b1, 2, 1'b1);
    run_job(1'b0, 10, 5, 1'b0, 1, 1'b1);
    // R4: degenerate sizes where clamping dominates
    run_job(1'b1, 3, 1, 1'b1, 1, 1'b0);
    run_job(1'b0, 1, 2, 1'b1, 2, 1'b0);
    run_job(1'b1, 1, 3, 1'b0, 0, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule